// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of an event timer. It watches a free-running 64-bit main counter, supplied from outside, and compares it against a target that software programs. When the counter reaches the target, the block emits a one-cycle expiry pulse. The channel runs either once (one-shot) or repeatedly (periodic). An optional narrow mode limits the comparator to 32 bits and places the target relative to the current counter value.

Software programs the channel through a write strobe that addresses either the configuration word or the comparator word. Each write is a low half, a high half or a full 64-bit word. Every write is accepted in the cycle it is presented, so the write port has no back-pressure. The visible comparator is always readable on `cmp_o`. In periodic mode the channel advances it by the period after each expiry. Whenever the global enable is high, the channel rebuilds its internal 64-bit target from the current counter after each write, and again on the rising edge of the enable.

Top module: `evt_timer_chan`

## Requirements
- R1: While reset is held and after it is released, `cmp_o` reads all ones and `fire_o` is low. The channel is disarmed until the global enable rises.
- R2: In 64-bit one-shot mode (config bits periodic=0, narrow=0), `fire_o` pulses high for exactly one cycle in the cycle after the first clock edge at which the counter is no longer before the target. It does not pulse again until the channel is reprogrammed.
- R3: "Before" means that target minus counter, taken as a signed 64-bit value, is positive. A target just past 2^64 is therefore reached after the counter wraps through zero.
- R4: Write encoding: `wr_sel_i`=0 selects config and 1 selects the comparator. `wr_part_i` is 01 for the low half, 10 for the high half and 11 for the full word. A half value is carried on `wr_data_i[31:0]`. Config bits are [0] periodic, [1] narrow and [2] set-value. A comparator write in periodic mode always loads the hidden period. It loads the visible comparator only if set-value is 1 or the channel is one-shot.
- R5: Every accepted comparator write clears the set-value bit.
- R6: On a periodic expiry with a nonzero period, the period is added to the target, one addition per cycle, until the target lies after the counter. `cmp_o` follows each new target, truncated to 32 bits in narrow mode.
- R7: A periodic channel with a zero period fires once and does not re-arm.
- R8: In narrow mode the target is the counter with its low 32 bits replaced by the comparator. If that value is below the counter, 2^32 is added.
- R9: In narrow one-shot mode, if the target lies beyond the next wrap point (the counter with its low 32 bits set to ones, plus one), one event fires at the wrap point and a second at the target.
- R10: In narrow mode a high-half comparator write is ignored. A low-half or full write zero-extends its low 32 bits.
- R11: A config write that leaves the narrow bit set clears the upper 32 bits of the comparator and the period.
- R12: While the enable is low nothing fires. A write while the enable is high, or a rising enable, rebuilds the target from the current counter. No event fires in that cycle, and a target that is already passed fires in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable |
| wr_en_i | input | 1 | Register write strobe, always accepted |
| wr_sel_i | input | 1 | 0 = config word, 1 = comparator word |
| wr_part_i | input | 2 | 01 low half, 10 high half, 11 full word |
| wr_data_i | input | 64 | Write data; a half value uses bits [31:0] |
| fire_o | output | 1 | One-cycle expiry pulse |
| cmp_o | output | 64 | Visible comparator value |

## Verification
The bench builds the block with its default widths: a 64-bit counter and a 32-bit narrow half. The counter is an input driven by the bench, so it can be loaded next to 2^32 and 2^64 boundaries directly. The wrap event, the target placement past 2^32 and the signed wraparound compare are therefore reached within tens of cycles. The same default widths also put catch-up sequences and high-half write merging inside short directed runs and a random phase.

// File: rtl/tchan_pkg.sv
package tchan_pkg;
  // config word layout: [2] set-value, [1] narrow, [0] periodic
  typedef struct packed {
    logic setval;
    logic narrow;
    logic periodic;
  } tcfg_t;

  localparam logic [1:0] PART_LO  = 2'b01;
  localparam logic [1:0] PART_HI  = 2'b10;
  localparam logic [1:0] PART_ALL = 2'b11;
endpackage

// File: rtl/tchan_regs.sv
module tchan_regs
  import tchan_pkg::*;
#(
  parameter int CW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [1:0]    wr_part_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [CW-1:0] upd_val_i,
  output tcfg_t         cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] per_o,
  output tcfg_t         nx_cfg_o,
  output logic [CW-1:0] nx_cmp_o,
  output logic          take_o
);
  localparam logic [CW-1:0] LOMASK = {{(CW-HW){1'b0}}, {HW{1'b1}}};

  tcfg_t         cfg_q, cfg_nx;
  logic [CW-1:0] cmp_q, cmp_nx, per_q, per_nx;
  logic [CW-1:0] zext_v, cmp_wv, per_wv;
  logic          take;

  function automatic logic [CW-1:0] merge(logic [CW-1:0] old, logic [1:0] part,
                                          logic [CW-1:0] d);
    logic [CW-1:0] r;
    r = old;
    if (part[0]) r[HW-1:0] = d[HW-1:0];
    if (part[1]) r[CW-1:HW] = (part == PART_ALL) ? d[CW-1:HW] : d[HW-1:0];
    return r;
  endfunction

  always_comb begin
    zext_v = {{(CW-HW){1'b0}}, wr_data_i[HW-1:0]};
    cmp_wv = cfg_q.narrow ? zext_v : merge(cmp_q, wr_part_i, wr_data_i);
    per_wv = cfg_q.narrow ? zext_v : merge(per_q, wr_part_i, wr_data_i);
    take   = wr_en_i && (wr_part_i != 2'b00)
             && !(wr_sel_i && cfg_q.narrow && (wr_part_i == PART_HI));
    cfg_nx = cfg_q;
    cmp_nx = cmp_q;
    per_nx = per_q;
    if (upd_en_i) cmp_nx = upd_val_i;
    if (take) begin
      if (!wr_sel_i) begin
        if (wr_part_i[0]) cfg_nx = wr_data_i[2:0];
        if (cfg_nx.narrow) begin
          cmp_nx = cmp_nx & LOMASK;
          per_nx = per_nx & LOMASK;
        end
      end else begin
        if (!cfg_q.periodic || cfg_q.setval) cmp_nx = cmp_wv;
        if (cfg_q.periodic) per_nx = per_wv;
        cfg_nx.setval = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cfg_q <= cfg_nx;
      cmp_q <= cmp_nx;
      per_q <= per_nx;
    end
  end

  assign cfg_o    = cfg_q;
  assign cmp_o    = cmp_q;
  assign per_o    = per_q;
  assign nx_cfg_o = cfg_nx;
  assign nx_cmp_o = cmp_nx;
  assign take_o   = take;

  // R10: upper-half comparator write in narrow mode leaves the comparator alone
  a_r10_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i && cfg_q.narrow && wr_part_i == PART_HI && !upd_en_i)
    |=> $stable(cmp_q));

  // R5: set-value drops after an accepted comparator write
  a_r5_setval_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i && wr_part_i != 2'b00
     && !(cfg_q.narrow && wr_part_i == PART_HI))
    |=> !cfg_q.setval);

  // R11: narrow mode keeps the upper halves cleared
  a_r11_narrow_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.narrow |-> (cmp_q[CW-1:HW] == '0 && per_q[CW-1:HW] == '0));
endmodule

// File: rtl/tchan_arm.sv
module tchan_arm #(
  parameter int CW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          glb_en_i,
  input  logic          wr_take_i,
  input  logic          nx_narrow_i,
  input  logic          nx_periodic_i,
  input  logic [CW-1:0] nx_cmp_i,
  input  logic          cur_narrow_i,
  input  logic          cur_periodic_i,
  input  logic [CW-1:0] per_i,
  output logic          fire_o,
  output logic          upd_en_o,
  output logic [CW-1:0] upd_val_o
);
  localparam logic [CW-1:0] LOMASK = {{(CW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] HSTEP  = LOMASK + ONE;

  logic [CW-1:0] tgt_q, arm_q, new_tgt, nt, wrap_pt;
  logic          armed_q, wrap_q, catch_q, en_q, fire_q;
  logic          reprog, hit, per_live, catch_done;

  // a lies strictly before b when b - a is a positive signed value
  function automatic logic is_before(logic [CW-1:0] a, logic [CW-1:0] b);
    logic [CW-1:0] d;
    d = b - a;
    return !d[CW-1] && (d != '0);
  endfunction

  function automatic logic [CW-1:0] eff_target(logic [CW-1:0] cnt, logic [CW-1:0] cm,
                                               logic nar);
    logic [CW-1:0] t;
    if (!nar) return cm;
    t = (cnt & ~LOMASK) | (cm & LOMASK);
    if (t < cnt) t = t + HSTEP;
    return t;
  endfunction

  always_comb begin
    reprog     = glb_en_i && (wr_take_i || !en_q);
    hit        = armed_q && glb_en_i && !catch_q && !reprog && !is_before(count_i, arm_q);
    per_live   = cur_periodic_i && (per_i != '0);
    nt         = tgt_q + per_i;
    catch_done = is_before(count_i, tgt_q);
    upd_en_o   = !reprog && glb_en_i
                 && ((catch_q && !catch_done) || (hit && per_live));
    upd_val_o  = cur_narrow_i ? (nt & LOMASK) : nt;
    new_tgt    = eff_target(count_i, nx_cmp_i, nx_narrow_i);
    wrap_pt    = (count_i | LOMASK) + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      arm_q   <= '0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      catch_q <= 1'b0;
      en_q    <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      en_q   <= glb_en_i;
      fire_q <= hit;
      if (reprog) begin
        tgt_q   <= new_tgt;
        armed_q <= 1'b1;
        catch_q <= 1'b0;
        if (nx_narrow_i && !nx_periodic_i && (new_tgt > wrap_pt)) begin
          wrap_q <= 1'b1;
          arm_q  <= wrap_pt;
        end else begin
          wrap_q <= 1'b0;
          arm_q  <= new_tgt;
        end
      end else if (catch_q && glb_en_i) begin
        if (catch_done) begin
          catch_q <= 1'b0;
        end else begin
          tgt_q <= nt;
          arm_q <= nt;
        end
      end else if (hit) begin
        if (per_live) begin
          tgt_q   <= nt;
          arm_q   <= nt;
          catch_q <= 1'b1;
        end else if (wrap_q) begin
          wrap_q <= 1'b0;
          arm_q  <= tgt_q;
        end else begin
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign fire_o = fire_q;

  // R12: an expiry is only reported for a cycle in which the enable was high
  a_r12_fire_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(glb_en_i));

  // R9: a pending wrap event always sits on a wrap point
  a_r9_wrap_point: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (arm_q[HW-1:0] == '0));
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import tchan_pkg::*;
#(
  parameter int CW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic          glb_en_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [1:0]    wr_part_i,
  input  logic [CW-1:0] wr_data_i,
  output logic          fire_o,
  output logic [CW-1:0] cmp_o
);
  tcfg_t         cfg, nx_cfg;
  logic [CW-1:0] per, nx_cmp, upd_val;
  logic          take, upd_en;

  tchan_regs #(.CW(CW), .HW(HW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_part_i(wr_part_i),
    .wr_data_i(wr_data_i),
    .upd_en_i (upd_en),
    .upd_val_i(upd_val),
    .cfg_o    (cfg),
    .cmp_o    (cmp_o),
    .per_o    (per),
    .nx_cfg_o (nx_cfg),
    .nx_cmp_o (nx_cmp),
    .take_o   (take)
  );

  tchan_arm #(.CW(CW), .HW(HW)) u_arm (
    .clk           (clk),
    .rst_n         (rst_n),
    .count_i       (count_i),
    .glb_en_i      (glb_en_i),
    .wr_take_i     (take),
    .nx_narrow_i   (nx_cfg.narrow),
    .nx_periodic_i (nx_cfg.periodic),
    .nx_cmp_i      (nx_cmp),
    .cur_narrow_i  (cfg.narrow),
    .cur_periodic_i(cfg.periodic),
    .per_i         (per),
    .fire_o        (fire_o),
    .upd_en_o      (upd_en),
    .upd_val_o     (upd_val)
  );
endmodule

// File: tb/tb_evt_timer_chan.sv
`timescale 1ns/1ps
module tb_evt_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        en = 1'b0;
  logic        wen = 1'b0;
  logic        wsel = 1'b0;
  logic [1:0]  wpart = 2'b00;
  logic [63:0] wdata = '0;
  logic        fire_o;
  logic [63:0] cmp_o;

  always #2 clk = ~clk;

  evt_timer_chan dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(en),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_part_i(wpart), .wr_data_i(wdata),
    .fire_o(fire_o), .cmp_o(cmp_o)
  );

  int checks = 0, fails = 0, nfire = 0;
  bit done = 0;
  logic [63:0] adv = 64'd1, first_at, last_at;

  // reference state
  logic [2:0]  m_cfg;
  logic [63:0] m_cmp, m_per, m_tgt, m_arm;
  bit m_armed, m_wrap, m_catch, m_enq, m_fire;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit bef(logic [63:0] a, logic [63:0] b);
    logic [63:0] d;
    d = b - a;
    return !d[63] && (d != 0);
  endfunction

  function automatic logic [63:0] efft(logic [63:0] c, logic [63:0] cm, bit nar);
    logic [63:0] t;
    if (!nar) return cm;
    t = {c[63:32], cm[31:0]};
    if (t < c) t = t + 64'h1_0000_0000;
    return t;
  endfunction

  function automatic logic [63:0] mrg(logic [63:0] o, logic [1:0] p, logic [63:0] d);
    logic [63:0] r;
    r = o;
    if (p[0]) r[31:0] = d[31:0];
    if (p[1]) r[63:32] = (p == 2'b11) ? d[63:32] : d[31:0];
    return r;
  endfunction

  task automatic model_reset();
    m_cfg = 3'b000; m_cmp = '1; m_per = '0; m_tgt = '0; m_arm = '0;
    m_armed = 0; m_wrap = 0; m_catch = 0; m_enq = 0; m_fire = 0;
  endtask

  task automatic model_edge();
    bit take, rp, hit, upd;
    logic [63:0] nt, mc, mp, t, wp, cm, pe;
    logic [2:0] c;
    take = wen && wpart != 2'b00 && !(wsel && m_cfg[1] && wpart == 2'b10);
    rp   = en && (take || !m_enq);
    hit  = m_armed && en && !m_catch && !rp && !bef(cnt, m_arm);
    nt   = m_tgt + m_per;
    upd  = !rp && en && ((m_catch && !bef(cnt, m_tgt)) || (hit && m_cfg[0] && m_per != 0));
    c = m_cfg; cm = m_cmp; pe = m_per;
    if (upd) cm = m_cfg[1] ? {32'h0, nt[31:0]} : nt;
    if (take) begin
      if (!wsel) begin
        if (wpart[0]) c = wdata[2:0];
        if (c[1]) begin cm[63:32] = '0; pe[63:32] = '0; end
      end else begin
        if (m_cfg[1]) begin mc = {32'h0, wdata[31:0]}; mp = mc; end
        else begin mc = mrg(m_cmp, wpart, wdata); mp = mrg(m_per, wpart, wdata); end
        if (!m_cfg[0] || m_cfg[2]) cm = mc;
        if (m_cfg[0]) pe = mp;
        c[2] = 1'b0;
      end
    end
    if (rp) begin
      t = efft(cnt, cm, c[1]);
      wp = (cnt | 64'hFFFF_FFFF) + 64'd1;
      m_tgt = t; m_catch = 0; m_armed = 1;
      if (c[1] && !c[0] && t > wp) begin m_wrap = 1; m_arm = wp; end
      else begin m_wrap = 0; m_arm = t; end
    end else if (m_catch && en) begin
      if (bef(cnt, m_tgt)) m_catch = 0;
      else begin m_tgt = nt; m_arm = nt; end
    end else if (hit) begin
      if (m_cfg[0] && m_per != 0) begin m_tgt = nt; m_arm = nt; m_catch = 1; end
      else if (m_wrap) begin m_wrap = 0; m_arm = m_tgt; end
      else m_armed = 0;
    end
    m_cfg = c; m_cmp = cm; m_per = pe;
    m_fire = hit; m_enq = en;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "fire_o", {63'h0, fire_o}, {63'h0, m_fire});
    chk(tag, "cmp_o", cmp_o, m_cmp);
    if (fire_o) begin
      nfire++;
      if (nfire == 1) first_at = cnt;
      last_at = cnt;
    end
    wen = 1'b0;
    cnt = cnt + adv;
  endtask

  task automatic wr(bit sel, logic [1:0] part, logic [63:0] d, string tag);
    wen = 1'b1; wsel = sel; wpart = part; wdata = d;
    tick(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", "cmp_o in reset", cmp_o, '1);
    chk("R1", "fire_o in reset", {63'h0, fire_o}, 64'h0);
    rst_n = 1'b1;
    cnt = 64'd100; adv = 64'd1;
    run(3, "R1");
    chk("R1", "cmp_o after reset", cmp_o, '1);

    // R2: 64-bit one-shot
    wr(0, 2'b11, 64'h0, "R2");
    wr(1, 2'b11, 64'd120, "R2");
    nfire = 0; en = 1'b1;
    run(40, "R2");
    chk("R2", "one-shot event count", nfire, 1);
    chk("R2", "one-shot event counter value", first_at, 64'd120);
    en = 1'b0; tick("R2");

    // R3: target just past 2^64
    cnt = 64'hFFFF_FFFF_FFFF_FFF0;
    wr(1, 2'b11, 64'd5, "R3");
    nfire = 0; en = 1'b1;
    run(30, "R3");
    chk("R3", "wrapped event count", nfire, 1);
    chk("R3", "wrapped event counter value", first_at, 64'd5);
    en = 1'b0; tick("R3");

    // R4, R5, R6: periodic with set-value
    cnt = 64'd900; adv = 64'd4;
    wr(0, 2'b11, 64'h5, "R4");
    wr(1, 2'b11, 64'd1000, "R4");
    chk("R4", "set-value write loads comparator", cmp_o, 64'd1000);
    wr(1, 2'b11, 64'd200, "R5");
    chk("R5", "period-only write keeps comparator", cmp_o, 64'd1000);
    nfire = 0; en = 1'b1;
    run(150, "R6");
    chk("R6", "periodic event count", nfire, 3);
    chk("R6", "comparator after periodic events", cmp_o, 64'd1600);
    en = 1'b0; tick("R6");
    // R6 catch-up: enable long after the target
    cnt = 64'd2500; nfire = 0; en = 1'b1;
    run(10, "R6");
    chk("R6", "catch-up event count", nfire, 1);
    chk("R6", "comparator after catch-up", cmp_o, 64'd2600);
    en = 1'b0; tick("R6");

    // R7: zero period
    cnt = 64'd3000;
    wr(0, 2'b11, 64'h5, "R7");
    wr(1, 2'b11, 64'd3100, "R7");
    wr(1, 2'b11, 64'd0, "R7");
    nfire = 0; en = 1'b1;
    run(100, "R7");
    chk("R7", "zero period event count", nfire, 1);
    chk("R7", "zero period comparator", cmp_o, 64'd3100);
    en = 1'b0; tick("R7");

    // R11, R10, R8: narrow mode
    wr(0, 2'b11, 64'h0, "R11");
    wr(1, 2'b11, 64'hABCD_0000_0000_1234, "R11");
    chk("R11", "wide comparator", cmp_o, 64'hABCD_0000_0000_1234);
    wr(0, 2'b01, 64'h2, "R11");
    chk("R11", "truncated comparator", cmp_o, 64'h1234);
    wr(1, 2'b10, 64'h55, "R10");
    chk("R10", "high-half write ignored", cmp_o, 64'h1234);
    wr(1, 2'b11, 64'hFFFF_0000_0000_0777, "R10");
    chk("R10", "full write zero-extended", cmp_o, 64'h777);
    wr(1, 2'b01, 64'h2000, "R8");
    cnt = 64'h5_0000_1F00; adv = 64'd8; nfire = 0; en = 1'b1;
    run(40, "R8");
    chk("R8", "narrow event count", nfire, 1);
    chk("R8", "narrow event counter value", first_at, 64'h5_0000_2000);
    en = 1'b0; tick("R8");

    // R9: extra event at the wrap point
    cnt = 64'h1_FFFF_FFF0; adv = 64'd2;
    wr(1, 2'b01, 64'h10, "R9");
    nfire = 0; en = 1'b1;
    run(30, "R9");
    chk("R9", "wrap plus target event count", nfire, 2);
    chk("R9", "first event at wrap point", first_at, 64'h2_0000_0000);
    chk("R9", "second event at target", last_at, 64'h2_0000_0010);
    en = 1'b0; tick("R9");
    cnt = 64'h3_FFFF_FF00; adv = 64'd8;
    wr(1, 2'b01, 64'hFFFF_FFF8, "R9");
    nfire = 0; en = 1'b1;
    run(40, "R9");
    chk("R9", "no extra event below wrap", nfire, 1);
    en = 1'b0; tick("R9");

    // R12: enable gating and reprogramming
    wr(0, 2'b01, 64'h0, "R12");
    wr(1, 2'b11, 64'd5000, "R12");
    cnt = 64'd4900; adv = 64'd4; nfire = 0;
    run(50, "R12");
    chk("R12", "no event while disabled", nfire, 0);
    en = 1'b1;
    run(5, "R12");
    chk("R12", "passed target fires on enable", nfire, 1);
    nfire = 0;
    wr(1, 2'b11, 64'd6000, "R12");
    run(250, "R12");
    chk("R12", "rewritten target event count", nfire, 1);
    chk("R12", "rewritten target counter value", first_at, 64'd6000);

    // random phase, every cycle compared with the reference (R2, R6, R12)
    adv = 64'd1;
    for (int i = 0; i < 3000; i++) begin
      adv = 64'd1 + ($urandom % 4);
      if ($urandom % 20 == 0) en = ~en;
      if ($urandom % 12 == 0) begin
        logic [1:0] p;
        p = ($urandom % 3 == 0) ? 2'(1 + $urandom % 2) : 2'b11;
        if ($urandom % 4 == 0)
          wr(0, p, 64'($urandom % 8), "R12");
        else if (m_cfg[0] && !m_cfg[2])
          wr(1, p, 64'd16 + 64'($urandom % 300), "R6");
        else
          wr(1, p, cnt + 64'($urandom % 400), "R2");
      end else begin
        tick("R12");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule